// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out a single atomic read-modify-write on behalf of a 64-bit core. A request brings an operation code, an access size (32-bit word or 64-bit doubleword), a byte address and a source operand. The unit first reads the addressed location through a simple memory port. It then combines the old value with the operand and writes the result back. The old value is returned for the destination register.

Before any memory traffic, the request is screened. Undefined operation codes, and doubleword operations while the core is not in 64-bit mode, are rejected as illegal instructions. Addresses that are not a multiple of the access size raise a store-type misalignment. Any error from the memory port, whether in the read phase or the write phase, is reported as a store access fault. A faulting request never writes memory.

The unit handles one request at a time. It sequences through idle, read, write and done states, and it signals completion with a one-cycle response pulse.

Top module: `amo_unit`

## Requirements
- R1: `req_ready` is high only when the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request produces exactly one response, marked by `rsp_valid` high for a single cycle.
- R2: A request that passes screening first holds `mem_rd_req` with `mem_addr` and `mem_dword` until `mem_rd_ack` or `mem_rd_err`. After a successful read it holds `mem_wr_req` with `mem_wr_data` until `mem_wr_ack` or `mem_wr_err`. Read and write requests are never high together, and the address stays stable throughout.
- R3: The response data is the old memory value, never the new one. Operation codes: 0 swap, 1 add, 2 and, 3 or, 4 xor, 5 signed min, 6 signed max, 7 unsigned min, 8 unsigned max. For each code the written value is that function of the old value and the operand.
- R4: Swap writes the operand unchanged and still returns the old memory value.
- R5: Signed min/max compare the two values as two's-complement numbers of the access width. Unsigned min/max compare them as unsigned numbers of that width.
- R6: A word access (`req_dword`=0) uses only bits 31:0 of the operand and of `mem_rd_data`, and the written word is placed in bits 31:0 of `mem_wr_data`. The returned value is the old word sign-extended from bit 31 to 64 bits, for every operation including unsigned min/max. The neighbouring word in memory is untouched.
- R7: Operation codes 9 to 15 are rejected with cause 2 (illegal instruction), and so is a doubleword request while `mode64`=0. Either case issues no memory access and reports `rsp_tval`=0.
- R8: An address with bits 2:0 nonzero on a doubleword access, or bits 1:0 nonzero on a word access, gives cause 6 (store address misaligned) with `rsp_tval` equal to the address and no memory access. An illegal request takes priority over a misaligned one.
- R9: A read error gives cause 7 (store access fault) with `rsp_tval` equal to the address, and no write is issued.
- R10: A write error also gives cause 7 with the address in `rsp_tval`.
- R11: On a fault `rsp_fault`=1 and `rsp_data`=0. On success `rsp_fault`=0, `rsp_cause`=0 and `rsp_tval`=0.
- R12: The response arrives one cycle after the accepting edge for screening faults, one cycle after the edge that takes a read error, and one cycle after the edge that takes a write acknowledge or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode64 | input | 1 | Core is in 64-bit mode; doubleword operations allowed |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 4 | Operation code |
| req_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | AW | Byte address |
| req_operand | input | XLEN | Source operand |
| mem_rd_req | output | 1 | Read request |
| mem_wr_req | output | 1 | Write request |
| mem_addr | output | AW | Access address |
| mem_dword | output | 1 | Access size, 1 = doubleword |
| mem_wr_data | output | XLEN | Write data, word in bits 31:0 for word access |
| mem_rd_ack | input | 1 | Read completed, data valid |
| mem_rd_err | input | 1 | Read failed |
| mem_rd_data | input | XLEN | Read data, word in bits 31:0 for word access |
| mem_wr_ack | input | 1 | Write completed |
| mem_wr_err | input | 1 | Write failed |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Request ended in an exception |
| rsp_cause | output | 4 | Exception cause code |
| rsp_tval | output | AW | Faulting address for causes 6 and 7 |
| rsp_data | output | XLEN | Old memory value, sign-extended for word access |

## Verification
A screening fault is due one cycle after the accepting edge. A read error is due two cycles after it. A successful or write-faulted operation with an immediate-answering memory is due three cycles after it, plus one cycle for each cycle the memory model delays its read acknowledge. The bench counts falling edges from the accepting edge until `rsp_valid` is seen, and compares that count with the expected figure for each scenario, including a delayed read. It also checks that the pulse has dropped at the following falling edge. The memory model answers at falling edges and counts reads and writes, so the claims of no access and no write are checked through those counts and through the stored contents.

// File: rtl/amo_pkg.sv
// Shared types and constants for the atomic read-modify-write unit.
// Assumes a 4-bit operation code and a 4-bit exception cause field.
package amo_pkg;

    localparam int OP_W    = 4;
    localparam int CAUSE_W = 4;

    typedef enum logic [OP_W-1:0] {
        AMO_SWAP = 4'd0,
        AMO_ADD  = 4'd1,
        AMO_AND  = 4'd2,
        AMO_OR   = 4'd3,
        AMO_XOR  = 4'd4,
        AMO_MIN  = 4'd5,
        AMO_MAX  = 4'd6,
        AMO_MINU = 4'd7,
        AMO_MAXU = 4'd8
    } amo_op_e;

    localparam logic [OP_W-1:0] LAST_OP = 4'd8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } amo_state_e;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE     = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_ALIGN = 4'd6;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT = 4'd7;

endpackage

// File: rtl/amo_precheck.sv
// Request screening: decides before any memory access whether a request
// is illegal (unknown code, or doubleword outside 64-bit mode) or misaligned.
// Illegal wins over misaligned. Assumes XLEN is 64 (word = XLEN/2 bits).
module amo_precheck
    import amo_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 32
) (
    input  logic [OP_W-1:0]    op,
    input  logic               dword,
    input  logic               mode64,
    input  logic [AW-1:0]      addr,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause
);
    localparam int DW_LSB = $clog2(XLEN / 8);
    localparam int W_LSB  = $clog2(XLEN / 16);

    logic illegal;
    logic misaligned;

    // Classify the request and pick the cause with illegal first.
    always_comb begin
        illegal    = (op > LAST_OP) || (dword && !mode64);
        misaligned = dword ? (|addr[DW_LSB-1:0]) : (|addr[W_LSB-1:0]);
        fault      = illegal || misaligned;
        if (illegal)         cause = CAUSE_ILLEGAL;
        else if (misaligned) cause = CAUSE_ST_ALIGN;
        else                 cause = CAUSE_NONE;
    end

endmodule

// File: rtl/amo_alu_lane.sv
// One width of the combine function: new = f(old, operand).
// Comparisons for min/max are done at the lane width W.
module amo_alu_lane
    import amo_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    old_val,
    input  logic [W-1:0]    operand,
    output logic [W-1:0]    result
);
    logic lt_signed;
    logic lt_unsigned;

    // Compare old against operand in both number systems.
    always_comb begin
        lt_signed   = $signed(old_val) < $signed(operand);
        lt_unsigned = old_val < operand;
    end

    // Select the combined value for the operation code.
    always_comb begin
        case (op)
            AMO_SWAP: result = operand;
            AMO_ADD:  result = old_val + operand;
            AMO_AND:  result = old_val & operand;
            AMO_OR:   result = old_val | operand;
            AMO_XOR:  result = old_val ^ operand;
            AMO_MIN:  result = lt_signed   ? old_val : operand;
            AMO_MAX:  result = lt_signed   ? operand : old_val;
            AMO_MINU: result = lt_unsigned ? old_val : operand;
            AMO_MAXU: result = lt_unsigned ? operand : old_val;
            default:  result = old_val;
        endcase
    end

endmodule

// File: rtl/amo_alu.sv
// Combine stage holding a word lane and a doubleword lane; the access size
// selects one. The word result is zero-extended; only its low half is stored.
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [OP_W-1:0] op,
    input  logic            dword,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] result
);
    localparam int NLANE = 2;

    logic [XLEN-1:0] lane_res [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? XLEN / 2 : XLEN;
        logic [LW-1:0] r_lane;

        amo_alu_lane #(.W(LW)) u_lane (
            .op      (op),
            .old_val (old_val[LW-1:0]),
            .operand (operand[LW-1:0]),
            .result  (r_lane)
        );

        assign lane_res[g] = XLEN'(r_lane);
    end

    // Pick the lane matching the access size.
    always_comb result = dword ? lane_res[1] : lane_res[0];

endmodule

// File: rtl/amo_unit.sv
// Atomic read-modify-write unit. Screens a request, reads the location,
// writes f(old, operand) and returns the old value (word results
// sign-extended). Every memory error is reported as a store access fault.
// Assumes one request in flight and a memory port that answers each
// request exactly once with an acknowledge or an error.
module amo_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode64,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [OP_W-1:0]    req_op,
    input  logic               req_dword,
    input  logic [AW-1:0]      req_addr,
    input  logic [XLEN-1:0]    req_operand,
    output logic               mem_rd_req,
    output logic               mem_wr_req,
    output logic [AW-1:0]      mem_addr,
    output logic               mem_dword,
    output logic [XLEN-1:0]    mem_wr_data,
    input  logic               mem_rd_ack,
    input  logic               mem_rd_err,
    input  logic [XLEN-1:0]    mem_rd_data,
    input  logic               mem_wr_ack,
    input  logic               mem_wr_err,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic [AW-1:0]      rsp_tval,
    output logic [XLEN-1:0]    rsp_data
);
    localparam int HALF = XLEN / 2;

    amo_state_e         state_q;
    logic [OP_W-1:0]    op_q;
    logic               dword_q;
    logic [AW-1:0]      addr_q;
    logic [XLEN-1:0]    operand_q;
    logic [XLEN-1:0]    old_q;
    logic [XLEN-1:0]    new_q;
    logic               fault_q;
    logic [CAUSE_W-1:0] cause_q;

    logic               pre_fault;
    logic [CAUSE_W-1:0] pre_cause;
    logic [XLEN-1:0]    alu_res;
    logic               accept;

    amo_precheck #(.XLEN(XLEN), .AW(AW)) u_precheck (
        .op     (req_op),
        .dword  (req_dword),
        .mode64 (mode64),
        .addr   (req_addr),
        .fault  (pre_fault),
        .cause  (pre_cause)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op      (op_q),
        .dword   (dword_q),
        .old_val (mem_rd_data),
        .operand (operand_q),
        .result  (alu_res)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // Sequencer: idle -> read -> write -> done, short-cut to done on faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            dword_q   <= 1'b0;
            addr_q    <= '0;
            operand_q <= '0;
            old_q     <= '0;
            new_q     <= '0;
            fault_q   <= 1'b0;
            cause_q   <= CAUSE_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q      <= req_op;
                        dword_q   <= req_dword;
                        addr_q    <= req_addr;
                        operand_q <= req_operand;
                        old_q     <= '0;
                        fault_q   <= pre_fault;
                        cause_q   <= pre_cause;
                        state_q   <= pre_fault ? ST_DONE : ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_rd_err) begin
                        fault_q <= 1'b1;
                        cause_q <= CAUSE_ST_FAULT;
                        state_q <= ST_DONE;
                    end else if (mem_rd_ack) begin
                        old_q   <= mem_rd_data;
                        new_q   <= alu_res;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_err) begin
                        fault_q <= 1'b1;
                        cause_q <= CAUSE_ST_FAULT;
                        state_q <= ST_DONE;
                    end else if (mem_wr_ack) begin
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port and handshake outputs decoded from the state.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_rd_req  = (state_q == ST_READ);
        mem_wr_req  = (state_q == ST_WRITE);
        mem_addr    = addr_q;
        mem_dword   = dword_q;
        mem_wr_data = new_q;
    end

    // Response formatting: old value (sign-extended for words) or fault info.
    always_comb begin
        rsp_valid = (state_q == ST_DONE);
        rsp_fault = fault_q;
        rsp_cause = fault_q ? cause_q : CAUSE_NONE;
        rsp_tval  = (fault_q && cause_q != CAUSE_ILLEGAL) ? addr_q : '0;
        if (fault_q)      rsp_data = '0;
        else if (dword_q) rsp_data = old_q;
        else              rsp_data = {{HALF{old_q[HALF-1]}}, old_q[HALF-1:0]};
    end

    // R2: the port never reads and writes in the same cycle.
    assert_port_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    // R2: a write only starts right after a read that was acknowledged.
    assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_req) |-> $past(mem_rd_req && mem_rd_ack && !mem_rd_err));

    // R2: address held while the port is busy across cycles.
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_req || mem_wr_req) && $past(mem_rd_req || mem_wr_req)) |-> $stable(mem_addr));

    // R9: a read error never leads to a write.
    assert_no_write_on_rderr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_err) |=> !mem_wr_req);

    // R1: the response is a single-cycle pulse.
    assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: a misalignment answer comes straight from idle, with no access.
    assert_misalign_no_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == CAUSE_ST_ALIGN) |-> $past(req_ready && !mem_rd_req));

    // R1: no new request is taken while a response is outstanding.
    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req || rsp_valid) |-> !req_ready);

endmodule

// File: tb/tb_amo_unit.sv
// Directed bench for amo_unit with a falling-edge memory model.
module tb_amo_unit;
    localparam int XLEN = 64;
    localparam int AW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode64 = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [3:0]      req_op = '0;
    logic            req_dword = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [XLEN-1:0] req_operand = '0;
    logic            mem_rd_req, mem_wr_req, mem_dword;
    logic [AW-1:0]   mem_addr;
    logic [XLEN-1:0] mem_wr_data;
    logic            mem_rd_ack = 1'b0, mem_rd_err = 1'b0;
    logic [XLEN-1:0] mem_rd_data = '0;
    logic            mem_wr_ack = 1'b0, mem_wr_err = 1'b0;
    logic            rsp_valid, rsp_fault;
    logic [3:0]      rsp_cause;
    logic [AW-1:0]   rsp_tval;
    logic [XLEN-1:0] rsp_data;

    always #5 clk = ~clk;

    amo_unit #(.XLEN(XLEN), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .mode64(mode64),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_dword(req_dword), .req_addr(req_addr), .req_operand(req_operand),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
        .mem_dword(mem_dword), .mem_wr_data(mem_wr_data),
        .mem_rd_ack(mem_rd_ack), .mem_rd_err(mem_rd_err), .mem_rd_data(mem_rd_data),
        .mem_wr_ack(mem_wr_ack), .mem_wr_err(mem_wr_err),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_tval(rsp_tval), .rsp_data(rsp_data)
    );

    // ---------------- memory model ----------------
    logic [63:0] mem [8];
    logic        p_en = 1'b0;
    logic [2:0]  p_idx = '0;
    logic [63:0] p_val = '0;
    int          rd_lat = 0;
    logic        rd_err_on = 1'b0, wr_err_on = 1'b0;
    logic [AW-1:0] rd_err_a = '0, wr_err_a = '0;
    int          rd_count = 0, wr_count = 0, wait_cnt = 0;

    always @(negedge clk) begin
        mem_rd_ack <= 1'b0;
        mem_rd_err <= 1'b0;
        mem_wr_ack <= 1'b0;
        mem_wr_err <= 1'b0;
        if (p_en) mem[p_idx] <= p_val;
        if (mem_rd_req) begin
            if (wait_cnt >= rd_lat) begin
                wait_cnt <= 0;
                rd_count <= rd_count + 1;
                if (rd_err_on && mem_addr == rd_err_a) mem_rd_err <= 1'b1;
                else begin
                    mem_rd_ack <= 1'b1;
                    if (mem_dword) mem_rd_data <= mem[mem_addr[5:3]];
                    else if (mem_addr[2]) mem_rd_data <= {32'hDEADBEEF, mem[mem_addr[5:3]][63:32]};
                    else mem_rd_data <= {32'hDEADBEEF, mem[mem_addr[5:3]][31:0]};
                end
            end else wait_cnt <= wait_cnt + 1;
        end else wait_cnt <= 0;
        if (mem_wr_req) begin
            wr_count <= wr_count + 1;
            if (wr_err_on && mem_addr == wr_err_a) mem_wr_err <= 1'b1;
            else begin
                mem_wr_ack <= 1'b1;
                if (mem_dword) mem[mem_addr[5:3]] <= mem_wr_data;
                else if (mem_addr[2]) mem[mem_addr[5:3]][63:32] <= mem_wr_data[31:0];
                else mem[mem_addr[5:3]][31:0] <= mem_wr_data[31:0];
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int total = 0;
    int bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [63:0] val);
        @(posedge clk);
        #1;
        p_en = 1'b1;
        p_idx = 3'(idx);
        p_val = val;
        @(negedge clk);
        #1;
        p_en = 1'b0;
    endtask

    logic [63:0] r_data;
    logic        r_fault;
    logic [3:0]  r_cause;
    logic [AW-1:0] r_tval;
    int          r_lat;
    logic        r_pulse_ok;

    task automatic do_amo(input logic [3:0] op, input logic dw,
                          input logic [AW-1:0] addr, input logic [63:0] opnd);
        int n;
        @(negedge clk);
        chk("R1 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_op = op;
        req_dword = dw;
        req_addr = addr;
        req_operand = opnd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_operand = 64'h5A5A_5A5A_5A5A_5A5A;
        n = 1;
        while (!rsp_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        r_lat = n;
        r_data = rsp_data;
        r_fault = rsp_fault;
        r_cause = rsp_cause;
        r_tval = rsp_tval;
        @(negedge clk);
        r_pulse_ok = !rsp_valid;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R1 reset no response", 64'(rsp_valid), 64'd0);
        chk("R2 reset no read", 64'(mem_rd_req), 64'd0);
        chk("R2 reset no write", 64'(mem_wr_req), 64'd0);
    endtask

    task automatic t_logic_add();
        poke(0, 64'h1111_2222_3333_4444);
        do_amo(4'd1, 1'b1, 32'h00, 64'h0000_0000_0000_1000);
        chk("R3 add returns old", r_data, 64'h1111_2222_3333_4444);
        chk("R3 add stores sum", mem[0], 64'h1111_2222_3333_5444);
        chk("R11 success no fault", {r_fault, r_cause, 28'(r_tval)}, 64'd0);
        chk("R12 success latency", 64'(r_lat), 64'd3);
        chk("R1 single pulse", 64'(r_pulse_ok), 64'd1);
        poke(1, 64'hFF00_FF00_FF00_FF00);
        do_amo(4'd2, 1'b1, 32'h08, 64'h0F0F_0F0F_0F0F_0F0F);
        chk("R3 and stores", mem[1], 64'h0F00_0F00_0F00_0F00);
        poke(2, 64'hFF00_FF00_FF00_FF00);
        do_amo(4'd3, 1'b1, 32'h10, 64'h0F0F_0F0F_0F0F_0F0F);
        chk("R3 or stores", mem[2], 64'hFF0F_FF0F_FF0F_FF0F);
        chk("R3 or returns old", r_data, 64'hFF00_FF00_FF00_FF00);
        poke(3, 64'hAAAA_AAAA_AAAA_AAAA);
        do_amo(4'd4, 1'b1, 32'h18, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R3 xor stores", mem[3], 64'h5555_5555_5555_5555);
    endtask

    task automatic t_swap();
        poke(4, 64'h0123_4567_89AB_CDEF);
        do_amo(4'd0, 1'b1, 32'h20, 64'hCAFE_F00D_1234_5678);
        chk("R4 swap returns old", r_data, 64'h0123_4567_89AB_CDEF);
        chk("R4 swap stores operand", mem[4], 64'hCAFE_F00D_1234_5678);
    endtask

    task automatic t_minmax_dword();
        poke(5, 64'hFFFF_FFFF_FFFF_FFFE);
        do_amo(4'd5, 1'b1, 32'h28, 64'd5);
        chk("R5 signed min keeps -2", mem[5], 64'hFFFF_FFFF_FFFF_FFFE);
        do_amo(4'd6, 1'b1, 32'h28, 64'd5);
        chk("R5 signed max picks 5", mem[5], 64'd5);
        poke(5, 64'hFFFF_FFFF_FFFF_FFFE);
        do_amo(4'd7, 1'b1, 32'h28, 64'd5);
        chk("R5 unsigned min picks 5", mem[5], 64'd5);
        do_amo(4'd8, 1'b1, 32'h28, 64'hFFFF_FFFF_FFFF_FFFE);
        chk("R5 unsigned max picks big", mem[5], 64'hFFFF_FFFF_FFFF_FFFE);
    endtask

    task automatic t_word();
        poke(6, 64'h8000_0001_7777_7777);
        do_amo(4'd5, 1'b0, 32'h34, 64'hFFFF_FFFF_0000_0002);
        chk("R5 word signed min keeps negative", mem[6], 64'h8000_0001_7777_7777);
        chk("R6 word result sign-extended", r_data, 64'hFFFF_FFFF_8000_0001);
        do_amo(4'd7, 1'b0, 32'h34, 64'hFFFF_FFFF_0000_0002);
        chk("R6 word unsigned min stores 2", mem[6], 64'h0000_0002_7777_7777);
        chk("R6 unsigned word still sign-extended", r_data, 64'hFFFF_FFFF_8000_0001);
        poke(7, 64'h1234_5678_FFFF_FFFF);
        do_amo(4'd1, 1'b0, 32'h38, 64'h0000_0000_0000_0001);
        chk("R6 word add no carry to neighbour", mem[7], 64'h1234_5678_0000_0000);
        chk("R6 word add returns -1", r_data, 64'hFFFF_FFFF_FFFF_FFFF);
        poke(7, 64'h1234_5678_7FFF_FFFF);
        do_amo(4'd6, 1'b0, 32'h38, 64'h0000_0000_0000_0003);
        chk("R6 positive word zero upper", r_data, 64'h0000_0000_7FFF_FFFF);
        chk("R5 word signed max keeps old", mem[7], 64'h1234_5678_7FFF_FFFF);
    endtask

    task automatic t_illegal();
        int rc;
        rc = rd_count;
        mode64 = 1'b0;
        do_amo(4'd1, 1'b1, 32'h00, 64'd1);
        chk("R7 dword outside 64-bit mode cause", 64'(r_cause), 64'd2);
        chk("R11 fault data zero", r_data, 64'd0);
        chk("R7 illegal tval zero", 64'(r_tval), 64'd0);
        chk("R12 screening latency", 64'(r_lat), 64'd1);
        do_amo(4'd1, 1'b1, 32'h04, 64'd1);
        chk("R8 illegal beats misaligned", 64'(r_cause), 64'd2);
        poke(0, 64'h0000_0000_0000_0010);
        do_amo(4'd1, 1'b0, 32'h00, 64'd1);
        chk("R7 word allowed outside 64-bit mode", mem[0], 64'h0000_0000_0000_0011);
        rc = rd_count;
        mode64 = 1'b1;
        do_amo(4'd12, 1'b0, 32'h00, 64'd1);
        chk("R7 undefined code cause", 64'(r_cause), 64'd2);
        chk("R7 undefined code no access", 64'(rd_count - rc), 64'd0);
    endtask

    task automatic t_misalign();
        int rc;
        rc = rd_count;
        do_amo(4'd1, 1'b1, 32'h0C, 64'd1);
        chk("R8 dword misaligned cause", 64'(r_cause), 64'd6);
        chk("R8 misaligned tval", 64'(r_tval), 64'h0C);
        chk("R8 fault flag", 64'(r_fault), 64'd1);
        do_amo(4'd1, 1'b0, 32'h02, 64'd1);
        chk("R8 word misaligned cause", 64'(r_cause), 64'd6);
        chk("R8 no memory access", 64'(rd_count - rc), 64'd0);
        chk("R12 misaligned latency", 64'(r_lat), 64'd1);
    endtask

    task automatic t_rd_err();
        int wc;
        poke(5, 64'h0000_0000_ABCD_0000);
        wc = wr_count;
        rd_err_on = 1'b1;
        rd_err_a = 32'h28;
        do_amo(4'd0, 1'b1, 32'h28, 64'd9);
        rd_err_on = 1'b0;
        chk("R9 read error store cause", 64'(r_cause), 64'd7);
        chk("R9 read error tval", 64'(r_tval), 64'h28);
        chk("R9 no write after read error", 64'(wr_count - wc), 64'd0);
        chk("R9 memory unchanged", mem[5], 64'h0000_0000_ABCD_0000);
        chk("R11 read error data zero", r_data, 64'd0);
        chk("R12 read error latency", 64'(r_lat), 64'd2);
    endtask

    task automatic t_wr_err();
        poke(6, 64'h0000_0000_0000_0042);
        wr_err_on = 1'b1;
        wr_err_a = 32'h30;
        do_amo(4'd1, 1'b1, 32'h30, 64'd1);
        wr_err_on = 1'b0;
        chk("R10 write error cause", 64'(r_cause), 64'd7);
        chk("R10 write error tval", 64'(r_tval), 64'h30);
        chk("R10 memory kept", mem[6], 64'h0000_0000_0000_0042);
        chk("R12 write error latency", 64'(r_lat), 64'd3);
    endtask

    task automatic t_slow_read();
        rd_lat = 3;
        poke(1, 64'd100);
        do_amo(4'd1, 1'b1, 32'h08, 64'd23);
        rd_lat = 0;
        chk("R12 delayed read latency", 64'(r_lat), 64'd6);
        chk("R3 delayed add stores", mem[1], 64'd123);
        chk("R3 delayed add returns old", r_data, 64'd100);
    endtask

    task automatic t_busy();
        @(negedge clk);
        req_valid = 1'b1;
        req_op = 4'd0;
        req_dword = 1'b1;
        req_addr = 32'h10;
        req_operand = 64'd77;
        @(posedge clk);
        @(negedge clk);
        chk("R1 not ready while busy", 64'(req_ready), 64'd0);
        chk("R2 read issued", 64'(mem_rd_req), 64'd1);
        @(negedge clk);
        chk("R2 write follows read", 64'(mem_wr_req), 64'd1);
        chk("R2 write data swap", mem_wr_data, 64'd77);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 idle again", 64'(req_ready), 64'd1);
        chk("R1 only one write for held valid", mem[2], 64'd77);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired R1 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        for (int i = 0; i < 8; i++) mem[i] = 64'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_logic_add();
        t_swap();
        t_minmax_dword();
        t_word();
        t_illegal();
        t_misalign();
        t_rd_err();
        t_wr_err();
        t_slow_read();
        t_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule